// File: doc/BRIEF.md
# Edge-Triggered Gated Compare Counter

This block is a compare counter whose running state is controlled by edges on an asynchronous trigger input. A qualifying trigger edge, rising or falling depending on a polarity select, starts the counter. While it runs, the counter advances by one on every clock where the count enable is high. A run ends in one of two ways: the count reaches the compare value, or a further trigger edge arrives first.

A mode select decides what an early second edge does. In stop mode the edge halts the counter and raises the sticky compare flag, and the next edge resumes counting from the held value. In reload mode the edge restarts the count from the load value and counting carries on. A separate select decides what happens at a compare match. The counter can freeze at the compare value until reset. It can also reload and wait for the next trigger, which turns the block into a retriggerable one-shot delay whose output flag rises at terminal count.

The output flag is cleared whenever the counter is (re)initialised, and set by a compare match. The compare flag stays set until a clear pulse removes it.

Top module: `trig_gate_counter`

## Requirements
- R1: While reset is asserted and directly after its release, count is 0 and both cmp_flag and out_flag are 0.
- R2: trig_in passes through a two-flop synchroniser. A qualifying change of trig_in set up before rising clock edge k takes effect at edge k+2, so the first increment can happen at edge k+3.
- R3: With trig_fall = 0 only a 0-to-1 change of trig_in qualifies. With trig_fall = 1 only a 1-to-0 change qualifies. The other direction has no effect on count or flags.
- R4: While running and not at the compare value, count rises by exactly one on each clock with cnt_en = 1, wrapping from all ones to 0. It holds on clocks with cnt_en = 0, and it always holds while stopped.
- R5: With retrig_reload = 0, a qualifying edge while running stops counting, holds count, and sets cmp_flag.
- R6: With retrig_reload = 0, a qualifying edge while stopped (before any compare match) resumes counting from the held value.
- R7: With retrig_reload = 1, a qualifying edge while running loads count from load_val on that clock, keeps the counter running and clears out_flag.
- R8: A compare match is a clock where the counter runs, cnt_en = 1 and count equals cmp_val. A match takes priority over a trigger edge on the same clock. With reinit_on_match = 0, a match sets cmp_flag and out_flag, stops counting and keeps count at cmp_val. Later triggers are then ignored until reset.
- R9: With reinit_on_match = 1, a match loads count from load_val, stops counting and sets cmp_flag and out_flag. The next qualifying edge starts a new run and clears out_flag.
- R10: cmp_flag stays set until flag_clr is high on a clock. If a flag-setting event happens on that same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Primary count enable, one step per high clock |
| trig_in | input | 1 | Asynchronous secondary trigger |
| trig_fall | input | 1 | 0: rising edges qualify, 1: falling edges qualify |
| retrig_reload | input | 1 | 0: early edge stops, 1: early edge reloads |
| reinit_on_match | input | 1 | 1: reload and stop at compare match (one-shot) |
| flag_clr | input | 1 | Clears cmp_flag |
| load_val | input | 16 | Reload value |
| cmp_val | input | 16 | Terminal (compare) value |
| count | output | 16 | Current count |
| cmp_flag | output | 1 | Sticky compare / early-stop flag |
| out_flag | output | 1 | Cleared on initialisation, set on compare |

## Verification
A wrong run state shows up at count within one enabled clock. A counter that should be stopped keeps advancing, and one that should be running stays flat. A synchroniser one stage too short or too long moves the first increment by a clock, which the per-clock comparison against the reference model catches straight away. A lost terminal state appears as a count that moves beyond cmp_val, or that accepts a trigger after the match, on the next enabled clock. Wrong flag priority shows as cmp_flag or out_flag differing on the clock right after a match, stop, reload or clear.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2
  } cnt_op_e;

  // qualifying transition between previous and current synchronised level
  function automatic logic edge_seen(input logic prev_lvl, input logic cur_lvl,
                                     input logic fall_sel);
    return fall_sel ? (prev_lvl & ~cur_lvl) : (~prev_lvl & cur_lvl);
  endfunction

endpackage

// File: rtl/tgc_edge_sync.sv
module tgc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic edge_pulse
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign edge_pulse = tgc_pkg::edge_seen(chain[STAGES], chain[STAGES-1], fall_sel);
endmodule

// File: rtl/tgc_run_ctrl.sv
module tgc_run_ctrl #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic            trig_edge,
  input  logic            retrig_reload,
  input  logic            reinit_on_match,
  input  logic            flag_clr,
  input  logic [W-1:0]    count,
  input  logic [W-1:0]    cmp_val,
  output tgc_pkg::cnt_op_e op,
  output logic            running,
  output logic            done,
  output logic            match_evt,
  output logic            cmp_flag,
  output logic            out_flag
);
  logic stop_evt, reload_evt, start_evt, step_evt;

  always_comb begin
    match_evt  = running & cnt_en & (count == cmp_val);
    stop_evt   = running & trig_edge & ~retrig_reload & ~match_evt;
    reload_evt = running & trig_edge &  retrig_reload & ~match_evt;
    start_evt  = ~running & ~done & trig_edge;
    step_evt   = running & cnt_en & ~match_evt & ~trig_edge;
    if ((match_evt & reinit_on_match) | reload_evt) op = tgc_pkg::OP_LOAD;
    else if (step_evt)                              op = tgc_pkg::OP_INC;
    else                                            op = tgc_pkg::OP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      done     <= 1'b0;
      cmp_flag <= 1'b0;
      out_flag <= 1'b0;
    end else begin
      if (match_evt | stop_evt) running <= 1'b0;
      else if (start_evt)       running <= 1'b1;

      if (match_evt & ~reinit_on_match) done <= 1'b1;

      if (match_evt | stop_evt) cmp_flag <= 1'b1;
      else if (flag_clr)        cmp_flag <= 1'b0;

      if (match_evt)                    out_flag <= 1'b1;
      else if (reload_evt | start_evt)  out_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tgc_count_reg.sv
module tgc_count_reg #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tgc_pkg::cnt_op_e op,
  input  logic [W-1:0]     load_val,
  output logic [W-1:0]     count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else begin
      unique case (op)
        tgc_pkg::OP_LOAD: count <= load_val;
        tgc_pkg::OP_INC:  count <= count + W'(1);
        default:          count <= count;
      endcase
    end
  end
endmodule

// File: rtl/trig_gate_counter.sv
module trig_gate_counter #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         trig_in,
  input  logic         trig_fall,
  input  logic         retrig_reload,
  input  logic         reinit_on_match,
  input  logic         flag_clr,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic         cmp_flag,
  output logic         out_flag
);
  logic             trig_edge;
  logic             running;
  logic             done;
  logic             match_evt;
  tgc_pkg::cnt_op_e op;

  tgc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_in), .fall_sel(trig_fall),
    .edge_pulse(trig_edge)
  );

  tgc_run_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .trig_edge(trig_edge),
    .retrig_reload(retrig_reload), .reinit_on_match(reinit_on_match),
    .flag_clr(flag_clr), .count(count), .cmp_val(cmp_val), .op(op),
    .running(running), .done(done), .match_evt(match_evt),
    .cmp_flag(cmp_flag), .out_flag(out_flag)
  );

  tgc_count_reg #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .op(op), .load_val(load_val), .count(count)
  );
endmodule

// File: rtl/tgc_checker.sv
module tgc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         trig_edge,
  input logic         retrig_reload,
  input logic         reinit_on_match,
  input logic         flag_clr,
  input logic [W-1:0] load_val,
  input logic [W-1:0] cmp_val,
  input logic [W-1:0] count,
  input logic         running,
  input logic         done,
  input logic         match_evt,
  input logic         cmp_flag,
  input logic         out_flag
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (count == '0) && !cmp_flag && !out_flag);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !done && trig_edge) |=> running);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !trig_edge) |=> $stable(count));

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cnt_en && !trig_edge) |=> $stable(count));

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && trig_edge && !retrig_reload && !match_evt) |=> (!running && cmp_flag));

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && trig_edge && retrig_reload && !match_evt)
      |=> (count == $past(load_val)) && running && !out_flag);

  p_hold_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !reinit_on_match)
      |=> (count == $past(cmp_val)) && done && cmp_flag && out_flag);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !running && $stable(count));

  p_reinit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && reinit_on_match)
      |=> (count == $past(load_val)) && !running && out_flag);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !flag_clr) |=> cmp_flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match_evt && !(running && trig_edge && !retrig_reload)) |=> !cmp_flag);
endmodule

bind trig_gate_counter tgc_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .trig_edge(trig_edge),
  .retrig_reload(retrig_reload), .reinit_on_match(reinit_on_match),
  .flag_clr(flag_clr), .load_val(load_val), .cmp_val(cmp_val),
  .count(count), .running(running), .done(done), .match_evt(match_evt),
  .cmp_flag(cmp_flag), .out_flag(out_flag)
);

// File: tb/tb_trig_gate_counter.sv
`timescale 1ns/1ps
module tb_trig_gate_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, trig_in = 1'b0, trig_fall = 1'b0;
  logic        retrig_reload = 1'b0, reinit_on_match = 1'b0, flag_clr = 1'b0;
  logic [15:0] load_val = '0, cmp_val = '0;
  logic [15:0] count;
  logic        cmp_flag, out_flag;

  int    n_run = 0, n_fail = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  trig_gate_counter dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .trig_in(trig_in),
    .trig_fall(trig_fall), .retrig_reload(retrig_reload),
    .reinit_on_match(reinit_on_match), .flag_clr(flag_clr),
    .load_val(load_val), .cmp_val(cmp_val), .count(count),
    .cmp_flag(cmp_flag), .out_flag(out_flag)
  );

  // behavioural reference model
  bit     hist[$];
  int     m_cnt;
  bit     m_run, m_done, m_cf, m_of, m_set, m_edge, m_cur, m_prv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_done = 0; m_cf = 0; m_of = 0;
      hist = '{0, 0, 0};
    end else begin
      hist.push_back(trig_in);
      m_cur = hist[hist.size()-3];
      m_prv = hist[hist.size()-4];
      void'(hist.pop_front());
      m_edge = trig_fall ? (m_prv && !m_cur) : (!m_prv && m_cur);
      m_set = 0;
      if (m_done) begin
      end else if (m_run && cnt_en && m_cnt == int'(cmp_val)) begin
        m_set = 1; m_of = 1; m_run = 0;
        if (reinit_on_match) m_cnt = int'(load_val);
        else m_done = 1;
      end else if (m_run && m_edge) begin
        if (retrig_reload) begin m_cnt = int'(load_val); m_of = 0; end
        else begin m_run = 0; m_set = 1; end
      end else if (!m_run && m_edge) begin
        m_run = 1; m_of = 0;
      end else if (m_run && cnt_en) begin
        m_cnt = (m_cnt + 1) % 65536;
      end
      if (m_set) m_cf = 1;
      else if (flag_clr) m_cf = 0;
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({tag, " count vs model"}, int'(count), m_cnt);
      chk({tag, " cmp_flag vs model"}, int'(cmp_flag), int'(m_cf));
      chk({tag, " out_flag vs model"}, int'(out_flag), int'(m_of));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; trig_in = 1'b0;
    wait_cyc(2); rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    wait_cyc(1);
    chk("R1 count in reset", int'(count), 0);
    chk("R1 flags in reset", int'({cmp_flag, out_flag}), 0);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 count after release", int'(count), 0);

    // R2 latency, R4 gating, R5/R6 stop-restart, R8 hold at compare
    tag = "R2"; cmp_val = 16'd20; load_val = 16'd0; cnt_en = 1'b1;
    trig_in = 1'b1;
    wait_cyc(3);
    chk("R2 no increment before third edge", int'(count), 0);
    wait_cyc(1);
    chk("R2 first increment", int'(count), 1);
    tag = "R4";
    for (int i = 0; i < 8; i++) begin cnt_en = i[0]; wait_cyc(1); end
    cnt_en = 1'b1;
    tag = "R3"; trig_in = 1'b0; wait_cyc(4);
    tag = "R5"; trig_in = 1'b1; wait_cyc(4);
    chk("R5 stop sets cmp_flag", int'(cmp_flag), 1);
    begin
      int held;
      held = int'(count);
      wait_cyc(3);
      chk("R5 count held after stop", int'(count), held);
    end
    tag = "R10"; flag_clr = 1'b1; wait_cyc(1); flag_clr = 1'b0;
    chk("R10 flag_clr clears cmp_flag", int'(cmp_flag), 0);
    tag = "R6"; trig_in = 1'b0; wait_cyc(4); trig_in = 1'b1; wait_cyc(6);
    tag = "R8"; wait_cyc(30);
    chk("R8 count held at compare", int'(count), 20);
    chk("R8 flags set at compare", int'({cmp_flag, out_flag}), 3);
    trig_in = 1'b0; wait_cyc(4); trig_in = 1'b1; wait_cyc(6);
    chk("R8 trigger ignored after match", int'(count), 20);
    tag = "R10"; wait_cyc(2);
    chk("R10 cmp_flag sticky", int'(cmp_flag), 1);

    // R3 falling-edge polarity
    do_reset(); tag = "R3"; trig_fall = 1'b1; cmp_val = 16'd500;
    trig_in = 1'b1; wait_cyc(8);
    chk("R3 rising edge ignored with falling select", int'(count), 0);
    trig_in = 1'b0; wait_cyc(6);
    chk("R3 falling edge starts count", int'(count), 3);

    // R7 reload on retrigger and R4 wrap
    do_reset(); tag = "R7"; trig_fall = 1'b0; retrig_reload = 1'b1;
    load_val = 16'd100; cmp_val = 16'd1000;
    trig_in = 1'b1; wait_cyc(10);
    chk("R7 counting before retrigger", int'(count), 7);
    trig_in = 1'b0; wait_cyc(4); trig_in = 1'b1; wait_cyc(3);
    chk("R7 retrigger reloads", int'(count), 100);
    chk("R7 out_flag cleared on reload", int'(out_flag), 0);
    wait_cyc(2);
    chk("R7 continues after reload", int'(count), 102);
    tag = "R4"; load_val = 16'hFFFE; cmp_val = 16'd2;
    trig_in = 1'b0; wait_cyc(4); trig_in = 1'b1; wait_cyc(3);
    chk("R4 reload near top", int'(count), 65534);
    wait_cyc(3);
    chk("R4 wrap to zero", int'(count), 1);
    wait_cyc(4);
    chk("R4 match after wrap", int'(count), 2);

    // R9 one-shot
    do_reset(); tag = "R9"; retrig_reload = 1'b0; reinit_on_match = 1'b1;
    load_val = 16'd0; cmp_val = 16'd4;
    trig_in = 1'b1; wait_cyc(10);
    chk("R9 reload after shot", int'(count), 0);
    chk("R9 out_flag set at terminal", int'(out_flag), 1);
    trig_in = 1'b0; wait_cyc(4); trig_in = 1'b1; wait_cyc(3);
    chk("R9 new shot clears out_flag", int'(out_flag), 0);
    wait_cyc(8);
    chk("R9 second shot fires", int'(out_flag), 1);

    wait_cyc(2);
    finish_run();
  end
endmodule